// File: doc/BRIEF.md
# End-of-Write Status Read Logic

This block produces the byte returned on the read side of a paged nonvolatile memory's data bus. While no internal programming cycle is running, a read returns the array byte at the presented address. While a programming cycle is in progress, the read returns a status byte that lets the host find out when the cycle has finished. The status byte reports completion in two ways at once. The most significant bit carries the inverted most significant bit of the last byte written, but only when the address read is the last one written. The next bit down inverts once after every completed read access.

A read access exists while chip-enable and output-enable are both low and write-enable is high. The same condition drives the output-enable of the external tristate driver. A read access ends when this condition drops, and the host can end it by raising output-enable, chip-enable, or both. The end is detected from a registered copy of the condition. When the busy flag drops, the bus returns true array data on the same cycle, with no pipeline delay.

Top module: `eow_status_read`

## Requirements
- R1: `drive_en` is high exactly when `ce_n` is 0, `oe_n` is 0 and `we_n` is 1, in the same cycle, for every combination of the three strobes.
- R2: While `drive_en` is low, `dout` is all zeros.
- R3: While `busy` is 0 and a read is active, `dout` equals `array_data`.
- R4: While `busy` is 1 and a read of `addr == last_addr` is active, bit DATA_W-1 of `dout` is the inverse of bit DATA_W-1 of `last_data`.
- R5: While `busy` is 1, a read of any address other than `last_addr` returns 0 in bit DATA_W-1.
- R6: While `busy` is 1, bits DATA_W-3 down to 0 of `dout` are zero.
- R7: While `busy` is 1, bit DATA_W-2 of `dout` (the toggle bit) inverts after each completed read access, so two successive reads show opposite values. The toggle bit is 0 after reset.
- R8: The toggle bit does not change during a read that stays active, and does not change for read accesses that complete while `busy` is 0.
- R9: When `busy` falls during an active read, `dout` shows `array_data` in that same cycle.
- R10: A read access ended by raising `oe_n` alone, `ce_n` alone, or both counts as a completed access for the toggle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Address of the current access |
| busy | input | 1 | High while an internal programming cycle runs |
| last_addr | input | ADDR_W | Address of the last byte loaded |
| last_data | input | DATA_W | Value of the last byte loaded |
| array_data | input | DATA_W | Array byte at `addr` |
| dout | output | DATA_W | Byte presented to the bus driver |
| drive_en | output | 1 | Output enable for the tristate driver |

## Verification
The bench sweeps every address of a small configuration in both the idle and the busy state, under several last-written values. A design that compared the wrong address or failed to invert the top bit would then show a wrong polling bit on exactly the hit or the miss reads. The toggle bit is tracked across hundreds of back-to-back reads that end alternately through output-enable, chip-enable and both. A design that flipped on the leading edge, flipped every cycle of a long read, or flipped while idle would fall out of step with the expected value. The bench also drops busy in the middle of an active read to catch a status path that is registered, and it drives all eight strobe combinations to catch a wrong output-enable decode, including a drive during a write.

// File: rtl/eow_status_read.sv
module eow_status_read #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout,
  output logic              drive_en
);
  localparam int POLL_B = DATA_W - 1;
  localparam int TOG_B  = DATA_W - 2;

  logic              rd_now;
  logic              rd_q;
  logic              tog;
  logic              addr_hit;
  logic [DATA_W-1:0] stat;

  assign rd_now   = !ce_n && !oe_n && we_n;
  assign addr_hit = (addr == last_addr);
  assign drive_en = rd_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tog  <= 1'b0;
    end else begin
      rd_q <= rd_now;
      if (busy && rd_q && !rd_now) tog <= ~tog;
    end
  end

  always_comb begin
    stat         = '0;
    stat[TOG_B]  = tog;
    stat[POLL_B] = addr_hit & ~last_data[POLL_B];
  end

  assign dout = !rd_now ? '0 : (busy ? stat : array_data);

  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> dout == '0);

  assert_true_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && !busy) |-> dout == array_data);

  assert_poll_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && busy && addr == last_addr) |-> dout[POLL_B] != last_data[POLL_B]);

  assert_poll_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && busy && addr != last_addr) |-> !dout[POLL_B]);

  generate
    if (DATA_W > 2) begin : g_low
      assert_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> dout[TOG_B-1:0] == '0);
    end
  endgenerate

  assert_tog_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q && !drive_en) |=> dout[TOG_B] != $past(stat[TOG_B]) || !drive_en || !busy);

  assert_tog_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || drive_en) |=> stat[TOG_B] == $past(stat[TOG_B]));
endmodule

// File: tb/eow_status_read_tb_top.sv
module eow_status_read_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, busy;
  logic [AW-1:0] addr, last_addr;
  logic [DW-1:0] last_data, array_data;
  logic [DW-1:0] dout;
  logic          drive_en;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic exp_tog;

  always #5 clk = ~clk;

  eow_status_read #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .busy(busy), .last_addr(last_addr), .last_data(last_data),
    .array_data(array_data), .dout(dout), .drive_en(drive_en));

  function automatic logic [DW-1:0] arr_val(input int a);
    return DW'((a * 37 + 5) % 256);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one full read: start, sample, end via mode (0: oe_n, 1: ce_n, 2: both)
  task automatic do_read(input int a, input int mode, output logic [DW-1:0] seen);
    @(negedge clk);
    addr = AW'(a);
    array_data = arr_val(a);
    ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    #1 seen = dout;
    if (mode == 0) oe_n = 1'b1;
    else if (mode == 1) ce_n = 1'b1;
    else begin oe_n = 1'b1; ce_n = 1'b1; end
    @(posedge clk);
    if (busy) exp_tog = ~exp_tog;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] seen, s2, expv;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; busy = 1'b0;
    addr = '0; last_addr = '0; last_data = '0; array_data = 8'h3C;
    exp_tog = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check(dout == 0 && drive_en == 0, "R2 reset state", dout, 0);
    rst_n = 1'b1;

    // R1/R2: all strobe combinations while idle
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      ce_n = c[0]; oe_n = c[1]; we_n = c[2];
      #1;
      check(drive_en == (!c[0] && !c[1] && c[2]), "R1 drive decode", drive_en, (!c[0] && !c[1] && c[2]));
      if (!drive_en) check(dout == 0, "R2 idle bus zero", dout, 0);
      else check(dout == array_data, "R3 strobe read", dout, array_data);
    end
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;

    // R3/R8: idle sweep, toggle must not move
    for (int a = 0; a < (1 << AW); a++) begin
      do_read(a, a % 3, seen);
      check(seen == arr_val(a), "R3 idle array data", seen, arr_val(a));
    end

    // R4..R7, R10: busy sweeps
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      last_data = (p == 0) ? 8'h00 : (p == 1) ? 8'h80 : (p == 2) ? 8'h5A : 8'hFF;
      last_addr = AW'(p * 5 + 2);
      busy = 1'b1;
      for (int a = 0; a < (1 << AW); a++) begin
        for (int m = 0; m < 3; m++) begin
          logic hit;
          hit = (AW'(a) == last_addr);
          expv = '0;
          expv[DW-1] = hit & ~last_data[DW-1];
          expv[DW-2] = exp_tog;
          do_read(a, m, seen);
          if (hit) check(seen[DW-1] == expv[DW-1], "R4 poll hit", seen, expv);
          else check(seen[DW-1] == 1'b0, "R5 poll miss", seen, expv);
          check(seen[DW-3:0] == 0, "R6 low bits zero", seen, expv);
          if (m == 0) check(seen[DW-2] == expv[DW-2], "R7 toggle after oe release", seen, expv);
          else check(seen[DW-2] == expv[DW-2], "R10 toggle after ce release", seen, expv);
        end
      end
    end

    // R8: long read does not toggle
    @(negedge clk);
    addr = last_addr; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); #1 seen = dout;
    repeat (4) @(negedge clk);
    #1 s2 = dout;
    check(seen == s2 && seen[DW-2] == exp_tog, "R8 long read stable", s2, seen);

    // R9: busy drops mid-read
    @(negedge clk);
    array_data = 8'hA7;
    busy = 1'b0;
    #1 check(dout == 8'hA7, "R9 true data at busy fall", dout, 8'hA7);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(posedge clk);
    @(negedge clk);

    // R8: idle reads after busy leave toggle alone
    for (int k = 0; k < 3; k++) do_read(k, k, seen);
    @(negedge clk);
    busy = 1'b1;
    do_read(1, 0, seen);
    check(seen[DW-2] == ~exp_tog, "R8 toggle held across idle reads", seen[DW-2], ~exp_tog);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule